// File: doc/BRIEF.md
# Dual-Clock Interprocessor Mailbox Controller

This block coordinates message exchange between two processors, side A and side B, that run on unrelated clocks. There are two message regions: region 0 carries traffic from A to B and region 1 carries traffic from B to A. Each region has an ownership semaphore and a message-ready flag. The message words themselves sit in an ordinary memory outside the block. The block holds only the ownership and signalling state that protects that memory.

Each side drives a one-cycle command strobe with an operation code and a region number. It reads back a status word:

- which semaphores that side holds,
- whether its outgoing message is still pending,
- a level interrupt that announces an incoming message.

Ownership is arbitrated in the side-A clock domain. Requests from side B travel there as toggles. The grant travels back to side B through a multi-flop synchronizer. Each ready flag is the XOR of a set toggle owned by the sender and a clear toggle owned by the receiver. Each toggle is synchronized into the other domain, so no single event can be lost or counted twice.

Top module: `mbx_dual_mailbox`

## Requirements
- R1: After reset, every status output of both sides (`a_own`, `b_own`, `a_tx_rdy`, `b_tx_rdy`, `a_irq`, `b_irq`) is low.
- R2: A command with op 0 (acquire) on a free semaphore makes the requester its owner, and bit i of that side's `own` output then reads 1 (i = 0 for the A-to-B region, i = 1 for the B-to-A region); a side owns a semaphore only when this readback shows it.
- R3: An acquire (op 0) of a semaphore already held by the other side is ignored, and the holder keeps it.
- R4: When both sides' acquire requests for a free semaphore reach the arbiter in the same side-A clock cycle, side A is granted it.
- R5: A release (op 1) frees a semaphore only when issued by its owner; a release by the non-owner leaves ownership unchanged.
- R6: A semaphore is never owned by both sides: after contending acquires have settled, exactly one side's `own` bit for that region is set.
- R7: A set-ready command (op 2, region field ignored) from side A sets the A-to-B flag only if A holds semaphore 0; from side B it sets the B-to-A flag only if B holds semaphore 1. Once set, the flag shows on the sender's `tx_rdy` and on the receiver's `irq`. A set while the flag is already high has no further effect.
- R8: A clear-ready command (op 3, region field ignored) from the receiving side lowers that flag, and afterwards both the receiver's `irq` and the sender's `tx_rdy` read low. A clear while the flag is low has no effect.
- R9: A stream of messages passed with acquire, set, wait-for-clear and release is delivered to the receiver exactly once each and in order, with the two clocks at unrelated periods.
- R10: The interrupt is level-sensitive and stays high until the receiving side issues a clear-ready command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Side-A clock; also clocks the semaphore arbiter |
| rst_a_n | input | 1 | Side-A asynchronous reset, active low |
| a_cmd_vld | input | 1 | Side-A command strobe, one cycle per command |
| a_cmd_op | input | 2 | Side-A operation: 0 acquire, 1 release, 2 set ready, 3 clear ready |
| a_cmd_sem | input | 1 | Side-A semaphore index for acquire and release |
| a_own | output | 2 | Semaphores held by side A, one bit per region |
| a_tx_rdy | output | 1 | A-to-B message still pending, as seen by side A |
| a_irq | output | 1 | Level interrupt: a B-to-A message is waiting |
| clk_b | input | 1 | Side-B clock |
| rst_b_n | input | 1 | Side-B asynchronous reset, active low |
| b_cmd_vld | input | 1 | Side-B command strobe, one cycle per command |
| b_cmd_op | input | 2 | Side-B operation, same coding as side A |
| b_cmd_sem | input | 1 | Side-B semaphore index for acquire and release |
| b_own | output | 2 | Semaphores held by side B, as seen in the side-B domain |
| b_tx_rdy | output | 1 | B-to-A message still pending, as seen by side B |
| b_irq | output | 1 | Level interrupt: an A-to-B message is waiting |

## Verification
A scripted sequence steps through acquire, release, set and clear from each side. It covers each command from the owner and from the non-owner, and each flag command given twice in a row. Together these separate a correct grant from a stolen one, and a single flag event from a repeated one.

A sweep then starts a side-B acquire and follows it with a side-A acquire of the same region, with the A request moved later by one more A cycle on each pass. Early passes let A win and late passes let B win. In every pass exactly one owner must remain.

Two back-to-back message streams, one in each direction, run with the clocks at unrelated periods. They check that each sequence number reaches the receiver exactly once and in order. The same-cycle tie in the arbiter cannot be aligned from outside the block, so a property checks it instead.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
   localparam int unsigned MBX_REGIONS = 2;
   localparam int unsigned MBX_SEM_W   = $clog2(MBX_REGIONS);
   localparam int unsigned REG_AB      = 0;
   localparam int unsigned REG_BA      = 1;

   typedef enum logic [1:0] {
      OP_ACQ = 2'd0,
      OP_REL = 2'd1,
      OP_SET = 2'd2,
      OP_CLR = 2'd3
   } mbx_op_e;

   typedef enum logic [1:0] {
      HOLD_NONE = 2'd0,
      HOLD_A    = 2'd1,
      HOLD_B    = 2'd2
   } mbx_holder_e;
endpackage

// File: rtl/mbx_sync.sv
`timescale 1ns/1ps
module mbx_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mbx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < int'(STAGES); s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_sem.sv
`timescale 1ns/1ps
module mbx_sem
   import mbx_pkg::*;
#(
   parameter int unsigned N_SEM = MBX_REGIONS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SEM-1:0] acq_a,
   input  logic [N_SEM-1:0] rel_a,
   input  logic [N_SEM-1:0] acq_b,
   input  logic [N_SEM-1:0] rel_b,
   output logic [N_SEM-1:0] own_a,
   output logic [N_SEM-1:0] own_b
);
   if (N_SEM < 1) begin : g_bad_count
      $error("mbx_sem: N_SEM must be at least 1");
   end

   for (genvar i = 0; i < int'(N_SEM); i++) begin : g_sem
      mbx_holder_e holder;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            holder <= HOLD_NONE;
         end else begin
            unique case (holder)
               HOLD_NONE: begin
                  if (acq_a[i])      holder <= HOLD_A;
                  else if (acq_b[i]) holder <= HOLD_B;
               end
               HOLD_A:  if (rel_a[i]) holder <= HOLD_NONE;
               HOLD_B:  if (rel_b[i]) holder <= HOLD_NONE;
               default: holder <= HOLD_NONE;
            endcase
         end
      end

      assign own_a[i] = (holder == HOLD_A);
      assign own_b[i] = (holder == HOLD_B);
   end
endmodule

// File: rtl/mbx_flag_end.sv
`timescale 1ns/1ps
module mbx_flag_end #(
   parameter int unsigned STAGES = 2,
   parameter bit          SETTER = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt,
   input  logic allow,
   input  logic peer_tog,
   output logic tog,
   output logic view
);
   logic peer_s;
   logic fire;

   mbx_sync #(.STAGES(STAGES), .WIDTH(1)) u_peer_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (peer_tog),
      .q    (peer_s)
   );

   assign view = tog ^ peer_s;

   if (SETTER) begin : g_setter
      assign fire = evt & allow & ~view;
   end else begin : g_clearer
      assign fire = evt & allow & view;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog <= 1'b0;
      else        tog <= tog ^ fire;
   end
endmodule

// File: rtl/mbx_dual_mailbox.sv
`timescale 1ns/1ps
module mbx_dual_mailbox
   import mbx_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                   clk_a,
   input  logic                   rst_a_n,
   input  logic                   a_cmd_vld,
   input  logic [1:0]             a_cmd_op,
   input  logic [MBX_SEM_W-1:0]   a_cmd_sem,
   output logic [MBX_REGIONS-1:0] a_own,
   output logic                   a_tx_rdy,
   output logic                   a_irq,
   input  logic                   clk_b,
   input  logic                   rst_b_n,
   input  logic                   b_cmd_vld,
   input  logic [1:0]             b_cmd_op,
   input  logic [MBX_SEM_W-1:0]   b_cmd_sem,
   output logic [MBX_REGIONS-1:0] b_own,
   output logic                   b_tx_rdy,
   output logic                   b_irq
);
   localparam int unsigned NR    = MBX_REGIONS;
   localparam int unsigned REQ_W = 2 * NR;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("mbx_dual_mailbox: SYNC_STAGES must be at least 2");
   end

   mbx_op_e a_op, b_op;
   assign a_op = mbx_op_e'(a_cmd_op);
   assign b_op = mbx_op_e'(b_cmd_op);

   logic [NR-1:0] a_acq, a_rel, b_acq_ev, b_rel_ev;
   for (genvar i = 0; i < int'(NR); i++) begin : g_dec
      assign a_acq[i]    = a_cmd_vld && (a_op == OP_ACQ) && (a_cmd_sem == MBX_SEM_W'(i));
      assign a_rel[i]    = a_cmd_vld && (a_op == OP_REL) && (a_cmd_sem == MBX_SEM_W'(i));
      assign b_acq_ev[i] = b_cmd_vld && (b_op == OP_ACQ) && (b_cmd_sem == MBX_SEM_W'(i));
      assign b_rel_ev[i] = b_cmd_vld && (b_op == OP_REL) && (b_cmd_sem == MBX_SEM_W'(i));
   end

   // side-B semaphore requests travel as toggles into the arbiter domain
   logic [NR-1:0] b_acq_tog, b_rel_tog;
   always_ff @(posedge clk_b or negedge rst_b_n) begin
      if (!rst_b_n) begin
         b_acq_tog <= '0;
         b_rel_tog <= '0;
      end else begin
         b_acq_tog <= b_acq_tog ^ b_acq_ev;
         b_rel_tog <= b_rel_tog ^ b_rel_ev;
      end
   end

   logic [REQ_W-1:0] req_s, req_d;
   logic [NR-1:0]    b_acq_p, b_rel_p;

   mbx_sync #(.STAGES(SYNC_STAGES), .WIDTH(REQ_W)) u_req_sync (
      .clk  (clk_a),
      .rst_n(rst_a_n),
      .d    ({b_rel_tog, b_acq_tog}),
      .q    (req_s)
   );

   always_ff @(posedge clk_a or negedge rst_a_n) begin
      if (!rst_a_n) req_d <= '0;
      else          req_d <= req_s;
   end
   assign {b_rel_p, b_acq_p} = req_s ^ req_d;

   logic [NR-1:0] sem_own_a, sem_own_b, b_own_src;

   mbx_sem #(.N_SEM(NR)) u_sem (
      .clk  (clk_a),
      .rst_n(rst_a_n),
      .acq_a(a_acq),
      .rel_a(a_rel),
      .acq_b(b_acq_p),
      .rel_b(b_rel_p),
      .own_a(sem_own_a),
      .own_b(sem_own_b)
   );
   assign a_own = sem_own_a;

   // registered before crossing so the synchronizer sees a glitch-free level
   always_ff @(posedge clk_a or negedge rst_a_n) begin
      if (!rst_a_n) b_own_src <= '0;
      else          b_own_src <= sem_own_b;
   end

   mbx_sync #(.STAGES(SYNC_STAGES), .WIDTH(NR)) u_own_sync (
      .clk  (clk_b),
      .rst_n(rst_b_n),
      .d    (b_own_src),
      .q    (b_own)
   );

   logic ab_set_tog, ab_clr_tog, ba_set_tog, ba_clr_tog;

   mbx_flag_end #(.STAGES(SYNC_STAGES), .SETTER(1'b1)) u_ab_tx (
      .clk     (clk_a),
      .rst_n   (rst_a_n),
      .evt     (a_cmd_vld && (a_op == OP_SET)),
      .allow   (sem_own_a[REG_AB]),
      .peer_tog(ab_clr_tog),
      .tog     (ab_set_tog),
      .view    (a_tx_rdy)
   );

   mbx_flag_end #(.STAGES(SYNC_STAGES), .SETTER(1'b0)) u_ab_rx (
      .clk     (clk_b),
      .rst_n   (rst_b_n),
      .evt     (b_cmd_vld && (b_op == OP_CLR)),
      .allow   (1'b1),
      .peer_tog(ab_set_tog),
      .tog     (ab_clr_tog),
      .view    (b_irq)
   );

   mbx_flag_end #(.STAGES(SYNC_STAGES), .SETTER(1'b1)) u_ba_tx (
      .clk     (clk_b),
      .rst_n   (rst_b_n),
      .evt     (b_cmd_vld && (b_op == OP_SET)),
      .allow   (b_own[REG_BA]),
      .peer_tog(ba_clr_tog),
      .tog     (ba_set_tog),
      .view    (b_tx_rdy)
   );

   mbx_flag_end #(.STAGES(SYNC_STAGES), .SETTER(1'b0)) u_ba_rx (
      .clk     (clk_a),
      .rst_n   (rst_a_n),
      .evt     (a_cmd_vld && (a_op == OP_CLR)),
      .allow   (1'b1),
      .peer_tog(ba_set_tog),
      .tog     (ba_clr_tog),
      .view    (a_irq)
   );
endmodule

// File: rtl/mbx_dual_mailbox_chk.sv
`timescale 1ns/1ps
module mbx_dual_mailbox_chk
   import mbx_pkg::*;
(
   input logic                   clk_a,
   input logic                   rst_a_n,
   input logic                   a_cmd_vld,
   input logic [1:0]             a_cmd_op,
   input logic [MBX_REGIONS-1:0] a_own,
   input logic                   a_tx_rdy,
   input logic                   a_irq,
   input logic                   clk_b,
   input logic                   rst_b_n,
   input logic                   b_cmd_vld,
   input logic [1:0]             b_cmd_op,
   input logic [MBX_REGIONS-1:0] b_own,
   input logic                   b_tx_rdy,
   input logic                   b_irq,
   input logic [MBX_REGIONS-1:0] a_acq,
   input logic [MBX_REGIONS-1:0] a_rel,
   input logic [MBX_REGIONS-1:0] b_acq_p,
   input logic [MBX_REGIONS-1:0] b_rel_p,
   input logic [MBX_REGIONS-1:0] own_b
);
   for (genvar i = 0; i < int'(MBX_REGIONS); i++) begin : g_reg
      AST_GRANT_NEEDS_REQ: assert property (@(posedge clk_a) disable iff (!rst_a_n)
         $rose(a_own[i]) |-> $past(a_acq[i])); // R2
      AST_HELD_NOT_STOLEN: assert property (@(posedge clk_a) disable iff (!rst_a_n)
         (own_b[i] && !b_rel_p[i]) |=> !a_own[i]); // R3
      AST_TIE_GOES_TO_A: assert property (@(posedge clk_a) disable iff (!rst_a_n)
         (a_acq[i] && b_acq_p[i] && !a_own[i] && !own_b[i]) |=> a_own[i]); // R4
      AST_OWNER_KEEPS: assert property (@(posedge clk_a) disable iff (!rst_a_n)
         (a_own[i] && !a_rel[i]) |=> a_own[i]); // R5
   end

   AST_A_SET_NEEDS_OWN: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      $rose(a_tx_rdy) |-> $past(a_own[REG_AB] && a_cmd_vld && (a_cmd_op == 2'd2))); // R7
   AST_B_SET_NEEDS_OWN: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      $rose(b_tx_rdy) |-> $past(b_own[REG_BA] && b_cmd_vld && (b_cmd_op == 2'd2))); // R7
   AST_A_IRQ_HOLDS: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      (a_irq && !(a_cmd_vld && (a_cmd_op == 2'd3))) |=> a_irq); // R10
   AST_B_IRQ_HOLDS: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      (b_irq && !(b_cmd_vld && (b_cmd_op == 2'd3))) |=> b_irq); // R10
endmodule

bind mbx_dual_mailbox mbx_dual_mailbox_chk u_chk (
   .clk_a    (clk_a),
   .rst_a_n  (rst_a_n),
   .a_cmd_vld(a_cmd_vld),
   .a_cmd_op (a_cmd_op),
   .a_own    (a_own),
   .a_tx_rdy (a_tx_rdy),
   .a_irq    (a_irq),
   .clk_b    (clk_b),
   .rst_b_n  (rst_b_n),
   .b_cmd_vld(b_cmd_vld),
   .b_cmd_op (b_cmd_op),
   .b_own    (b_own),
   .b_tx_rdy (b_tx_rdy),
   .b_irq    (b_irq),
   .a_acq    (a_acq),
   .a_rel    (a_rel),
   .b_acq_p  (b_acq_p),
   .b_rel_p  (b_rel_p),
   .own_b    (sem_own_b)
);

// File: tb/mbx_dual_mailbox_tb.sv
`timescale 1ns/1ps
module mbx_dual_mailbox_tb;
   localparam int NVEC = 18;
   localparam int NMSG = 20;

   // {side, op, sem, a_own, a_tx, a_irq, b_own, b_tx, b_irq, req}
   localparam logic [15:0] VEC [NVEC] = '{
      {1'b0, 2'd0, 1'b0, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'd2},  // R2 A takes region 0
      {1'b1, 2'd0, 1'b0, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'd3},  // R3 B blocked
      {1'b1, 2'd1, 1'b0, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'd5},  // R5 non-owner release
      {1'b0, 2'd2, 1'b0, 2'b01, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 4'd7},  // R7 A sets
      {1'b0, 2'd2, 1'b0, 2'b01, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 4'd7},  // R7 repeat set
      {1'b1, 2'd3, 1'b0, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'd8},  // R8 B clears
      {1'b1, 2'd3, 1'b0, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'd8},  // R8 repeat clear
      {1'b0, 2'd1, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'd5},  // R5 owner release
      {1'b1, 2'd0, 1'b1, 2'b00, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 4'd2},  // R2 B takes region 1
      {1'b1, 2'd2, 1'b0, 2'b00, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 4'd7},  // R7 B sets
      {1'b0, 2'd0, 1'b1, 2'b00, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 4'd3},  // R3 A blocked
      {1'b0, 2'd3, 1'b0, 2'b00, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 4'd8},  // R8 A clears
      {1'b1, 2'd1, 1'b1, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'd5},  // R5 B releases
      {1'b1, 2'd2, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'd7},  // R7 set without owning
      {1'b1, 2'd0, 1'b0, 2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 4'd2},  // R2 B takes region 0
      {1'b0, 2'd2, 1'b0, 2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 4'd7},  // R7 A set, B holds
      {1'b0, 2'd1, 1'b0, 2'b00, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 4'd5},  // R5 A non-owner release
      {1'b1, 2'd1, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 4'd5}   // R5 B releases
   };

   logic       clk_a = 1'b0, clk_b = 1'b0;
   logic       rst_a_n = 1'b0, rst_b_n = 1'b0;
   logic       a_cmd_vld = 1'b0, b_cmd_vld = 1'b0;
   logic [1:0] a_cmd_op = 2'd0, b_cmd_op = 2'd0;
   logic [0:0] a_cmd_sem = 1'b0, b_cmd_sem = 1'b0;
   logic [1:0] a_own, b_own;
   logic       a_tx_rdy, a_irq, b_tx_rdy, b_irq;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   int mem_ab = 0, mem_ba = 0;

   always #4    clk_a = ~clk_a;
   always #5.65 clk_b = ~clk_b;

   mbx_dual_mailbox u_dut (
      .clk_a(clk_a), .rst_a_n(rst_a_n), .a_cmd_vld(a_cmd_vld), .a_cmd_op(a_cmd_op),
      .a_cmd_sem(a_cmd_sem), .a_own(a_own), .a_tx_rdy(a_tx_rdy), .a_irq(a_irq),
      .clk_b(clk_b), .rst_b_n(rst_b_n), .b_cmd_vld(b_cmd_vld), .b_cmd_op(b_cmd_op),
      .b_cmd_sem(b_cmd_sem), .b_own(b_own), .b_tx_rdy(b_tx_rdy), .b_irq(b_irq)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cmd_a(input logic [1:0] op, input logic sem);
      @(negedge clk_a);
      a_cmd_vld = 1'b1; a_cmd_op = op; a_cmd_sem = sem;
      @(negedge clk_a);
      a_cmd_vld = 1'b0;
   endtask

   task automatic cmd_b(input logic [1:0] op, input logic sem);
      @(negedge clk_b);
      b_cmd_vld = 1'b1; b_cmd_op = op; b_cmd_sem = sem;
      @(negedge clk_b);
      b_cmd_vld = 1'b0;
   endtask

   task automatic settle();
      repeat (14) @(negedge clk_b);
      @(negedge clk_a);
   endtask

   function automatic int status();
      return int'({a_own, a_tx_rdy, a_irq, b_own, b_tx_rdy, b_irq});
   endfunction

   initial begin
      repeat (100000) @(posedge clk_a);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk_b);
      rst_a_n = 1'b1;
      rst_b_n = 1'b1;
      settle();
      check("R1 reset status", status(), 0);

      for (int k = 0; k < NVEC; k++) begin
         if (VEC[k][15]) cmd_b(VEC[k][14:13], VEC[k][12]);
         else            cmd_a(VEC[k][14:13], VEC[k][12]);
         settle();
         check($sformatf("R%0d vector %0d", VEC[k][3:0], k), status(), int'(VEC[k][11:4]));
      end

      // R6: contending acquires, A request moved later each pass
      for (int k = 0; k < 16; k++) begin
         cmd_b(2'd0, 1'b0);
         repeat (k) @(negedge clk_a);
         cmd_a(2'd0, 1'b0);
         settle();
         check($sformatf("R6 single owner pass %0d", k), int'(a_own[0] ^ b_own[0]), 1);
         cmd_a(2'd1, 1'b0);
         cmd_b(2'd1, 1'b0);
         settle();
         check("R5 both released", int'({a_own[0], b_own[0]}), 0);
      end

      // R9: A-to-B stream
      fork
         begin
            for (int m = 1; m <= NMSG; m++) begin
               cmd_a(2'd0, 1'b0);
               while (!a_own[0]) begin
                  repeat (3) @(negedge clk_a);
                  cmd_a(2'd0, 1'b0);
               end
               mem_ab = m;
               cmd_a(2'd2, 1'b0);
               while (a_tx_rdy) @(negedge clk_a);
               cmd_a(2'd1, 1'b0);
            end
         end
         begin
            for (int m = 1; m <= NMSG; m++) begin
               while (!b_irq) @(negedge clk_b);
               check("R9 A-to-B message", mem_ab, m);
               repeat (m % 3) @(negedge clk_b);
               check("R10 irq held until clear", int'(b_irq), 1);
               cmd_b(2'd3, 1'b0);
            end
         end
      join
      settle();
      check("R9 no extra A-to-B delivery", int'({b_irq, a_tx_rdy}), 0);

      // R9: B-to-A stream
      fork
         begin
            for (int m = 1; m <= NMSG; m++) begin
               cmd_b(2'd0, 1'b1);
               while (!b_own[1]) begin
                  repeat (3) @(negedge clk_b);
                  if (!b_own[1]) cmd_b(2'd0, 1'b1);
               end
               mem_ba = m + 100;
               cmd_b(2'd2, 1'b0);
               while (b_tx_rdy) @(negedge clk_b);
               cmd_b(2'd1, 1'b1);
               while (b_own[1]) @(negedge clk_b);
            end
         end
         begin
            for (int m = 1; m <= NMSG; m++) begin
               while (!a_irq) @(negedge clk_a);
               check("R9 B-to-A message", mem_ba, m + 100);
               cmd_a(2'd3, 1'b0);
            end
         end
      join
      settle();
      check("R9 no extra B-to-A delivery", int'({a_irq, b_tx_rdy}), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule